// File: doc/BRIEF.md
# Inter-Processor Command Mailbox

This block gives several processors a shared set of mailbox channels for short commands. A requester takes a free channel by writing its one-hot identifier into the channel's owner register. It then reads that register back, and the claim counts only if its own identifier returns. The owner sets the mode, the interrupt mask, the target set and the data words, and then fires the message with the send register. The receiving processor gets an interrupt. In automatic-acknowledge mode, the receiver clearing its interrupt moves the channel to the acknowledged state and interrupts the owner. The owner clears its own interrupt and writes its identifier to the owner register a second time, which frees the channel.

Software reaches every register through a plain 32-bit write port with a combinational read path. Each channel sits in its own 64-byte window. A key register sits above the channel windows. While the key is not written, every channel write is refused. Each requester position has one interrupt line, and it is the OR across all channels of that requester's pending bits where the channel mask does not suppress them.

Top module: `xcpu_mailbox`

## Requirements
- R1: Channel c sits at byte address c*64. Word offsets inside the window: 0x00 owner, 0x04 target set (write ORs bits in), 0x08 target clear (write removes bits), 0x0C target readback, 0x10 mode, 0x14 mask, 0x18 interrupt clear (a read returns the raw pending bits), 0x1C send, and data word k at 0x20+4k. A read of a window that has no channel returns 0.
- R2: The key register is at 0xA00. Reset leaves it locked, and reading it returns 1 while locked and 0 while open. Writing 0x1ACCE551 opens it, and writing any other value locks it again. While locked, every channel write is ignored.
- R3: On a free channel, a write to the owner register of a value with exactly one bit set, inside the requester width, makes that value the owner, and the owner register reads it back. A write of zero, of several bits, or of a bit above the requester width is ignored.
- R4: While a channel is claimed, an owner-register write of any value other than the current owner is ignored.
- R5: The owner writing its own identifier to the owner register frees the channel: owner reads 0, mode reads 0x10, and mask, targets and pending bits all read 0.
- R6: Mode register bits [7:4] hold one-hot state: 0x10 free, 0x20 claimed, 0x40 sent, 0x80 acknowledged. Bit 0 is the auto-acknowledge enable. Writes to mode, mask, targets and data take effect only while the channel is claimed.
- R7: Writing the owner's identifier to send, while the channel is claimed or acknowledged, moves it to sent and raises pending bits for the target set, or for every non-owner requester when the target set is empty. Any other send write is ignored.
- R8: In sent state with auto-acknowledge on, an interrupt-clear write that covers a pending non-owner bit removes those bits, moves the channel to acknowledged (mode reads 0x81), and raises the owner's pending bit.
- R9: With auto-acknowledge off, the same interrupt-clear write removes only the written pending bits, and the state stays sent.
- R10: Interrupt line r is high when some channel has pending bit r set and mask bit r clear. The mask gates only the line; the pending bits still read at 0x18.
- R11: The owner writing its identifier to interrupt clear drops its own pending bit and therefore its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | REQ_W (6) | One interrupt line per requester position |

## Verification
The bench goes after lost claim races. A design that let a foreign owner write through would hand a channel to two requesters, and the read-back check would then not catch it. The bench checks that the key relocks on a wrong value; a design that keeps the lock open would accept configuration writes from stray software. It separates auto and manual acknowledge, where a wrong design would report 0x80 while no acknowledge happened. It also checks that the mask leaves the pending bits intact, so that a design that cleared pending bits on mask would lose messages.

// File: rtl/xmb_pkg.sv
`timescale 1ns/1ps
package xmb_pkg;
   localparam int WIN_SHIFT = 6;
   localparam int DATA_BASE = 8;
   localparam logic [3:0] W_OWNER = 4'd0;
   localparam logic [3:0] W_TSET  = 4'd1;
   localparam logic [3:0] W_TCLR  = 4'd2;
   localparam logic [3:0] W_TSTAT = 4'd3;
   localparam logic [3:0] W_MODE  = 4'd4;
   localparam logic [3:0] W_MASK  = 4'd5;
   localparam logic [3:0] W_ICLR  = 4'd6;
   localparam logic [3:0] W_SEND  = 4'd7;

   typedef enum logic [3:0] {
      ST_FREE    = 4'b0001,
      ST_CLAIMED = 4'b0010,
      ST_SENT    = 4'b0100,
      ST_ACKED   = 4'b1000
   } chan_state_e;
endpackage

// File: rtl/xmb_keygate.sv
`timescale 1ns/1ps
module xmb_keygate #(
   parameter logic [31:0] KEY = 32'h1ACCE551
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic        unlocked_o
);
   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     open_q <= 1'b0;
      else if (wr_en) open_q <= (wdata == KEY);
   end

   assign unlocked_o = open_q;
endmodule

// File: rtl/xmb_channel.sv
`timescale 1ns/1ps
module xmb_channel
   import xmb_pkg::*;
#(
   parameter int REQ_W      = 6,
   parameter int DATA_WORDS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [3:0]       word_idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   output logic [REQ_W-1:0] owner_o,
   output logic [3:0]       state_o,
   output logic [REQ_W-1:0] irq_o
);
   localparam int PAD_W = 32 - REQ_W;

   if (REQ_W < 1 || REQ_W > 31) begin : g_bad_req
      $error("xmb_channel: REQ_W out of range");
   end
   if (DATA_WORDS < 1 || DATA_WORDS > 8) begin : g_bad_data
      $error("xmb_channel: DATA_WORDS out of range");
   end

   chan_state_e      state_q;
   logic [REQ_W-1:0] owner_q, mask_q, tgt_q, pend_q;
   logic             auto_q;
   logic [31:0]      data_q [DATA_WORDS];

   logic [REQ_W-1:0] wid, send_tgt, pend_clr;
   logic             id_ok, claimed, from_owner, ack_hit, send_ok;

   always_comb begin
      wid        = wdata[REQ_W-1:0];
      id_ok      = (wdata[31:REQ_W] == '0) && $onehot(wid);
      claimed    = (owner_q != '0);
      from_owner = claimed && (wdata == {{PAD_W{1'b0}}, owner_q});
      send_tgt   = (tgt_q != '0) ? tgt_q : ~owner_q;
      send_ok    = from_owner && (state_q == ST_CLAIMED || state_q == ST_ACKED);
      pend_clr   = pend_q & ~wid;
      ack_hit    = (state_q == ST_SENT) && auto_q && ((wid & ~owner_q & pend_q) != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FREE;
         owner_q <= '0;
         mask_q  <= '0;
         tgt_q   <= '0;
         pend_q  <= '0;
         auto_q  <= 1'b0;
      end else if (wr_en) begin
         case (word_idx)
            W_OWNER: begin
               if (!claimed && id_ok) begin
                  owner_q <= wid;
                  state_q <= ST_CLAIMED;
               end else if (from_owner) begin
                  owner_q <= '0;
                  state_q <= ST_FREE;
                  mask_q  <= '0;
                  tgt_q   <= '0;
                  pend_q  <= '0;
                  auto_q  <= 1'b0;
               end
            end
            W_TSET:  if (claimed) tgt_q  <= tgt_q | wid;
            W_TCLR:  if (claimed) tgt_q  <= tgt_q & ~wid;
            W_MODE:  if (claimed) auto_q <= wdata[0];
            W_MASK:  if (claimed) mask_q <= wid;
            W_ICLR: begin
               if (ack_hit) begin
                  pend_q  <= pend_clr | owner_q;
                  state_q <= ST_ACKED;
               end else begin
                  pend_q  <= pend_clr;
               end
            end
            W_SEND: begin
               if (send_ok) begin
                  pend_q  <= pend_q | send_tgt;
                  state_q <= ST_SENT;
               end
            end
            default: ;
         endcase
      end
   end

   for (genvar k = 0; k < DATA_WORDS; k++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data_q[k] <= '0;
         else if (wr_en && claimed && word_idx == 4'(DATA_BASE + k))
            data_q[k] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (word_idx)
         W_OWNER: rdata = {{PAD_W{1'b0}}, owner_q};
         W_TSTAT: rdata = {{PAD_W{1'b0}}, tgt_q};
         W_MODE:  rdata = {24'b0, state_q, 3'b0, auto_q};
         W_MASK:  rdata = {{PAD_W{1'b0}}, mask_q};
         W_ICLR:  rdata = {{PAD_W{1'b0}}, pend_q};
         default: begin
            if (word_idx[3] && ({1'b0, word_idx[2:0]} < 4'(DATA_WORDS)))
               rdata = data_q[word_idx[2:0]];
         end
      endcase
   end

   assign owner_o = owner_q;
   assign state_o = state_q;
   assign irq_o   = pend_q & ~mask_q;
endmodule

// File: rtl/xmb_irq_merge.sv
`timescale 1ns/1ps
module xmb_irq_merge #(
   parameter int NUM_CH = 5,
   parameter int REQ_W  = 6
) (
   input  logic [NUM_CH-1:0][REQ_W-1:0] irq_ch,
   output logic [REQ_W-1:0]             irq_o
);
   always_comb begin
      irq_o = '0;
      for (int c = 0; c < NUM_CH; c++) irq_o = irq_o | irq_ch[c];
   end
endmodule

// File: rtl/xcpu_mailbox.sv
`timescale 1ns/1ps
module xcpu_mailbox
   import xmb_pkg::*;
#(
   parameter int          NUM_CH     = 5,
   parameter int          REQ_W      = 6,
   parameter int          DATA_WORDS = 8,
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] LOCK_OFS   = 32'h0000_0A00,
   parameter logic [31:0] KEY        = 32'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [REQ_W-1:0]  irq
);
   localparam int CH_W = ADDR_W - WIN_SHIFT;

   if (ADDR_W <= WIN_SHIFT || ADDR_W > 31) begin : g_bad_addr
      $error("xcpu_mailbox: ADDR_W out of range");
   end
   if ((NUM_CH * (1 << WIN_SHIFT)) > int'(LOCK_OFS) || int'(LOCK_OFS) >= (1 << ADDR_W)) begin : g_bad_map
      $error("xcpu_mailbox: channel windows overlap the key register");
   end

   logic [31:0]                    addr_ext;
   logic [CH_W-1:0]                ch_idx;
   logic [3:0]                     word_idx;
   logic                           lock_hit, unlocked;
   logic [NUM_CH-1:0]              ch_hit;
   logic [NUM_CH-1:0][31:0]        ch_rd;
   logic [NUM_CH-1:0][REQ_W-1:0]   owner_all, irq_ch;
   logic [NUM_CH-1:0][3:0]         state_all;

   assign addr_ext = 32'(bus_addr);
   assign ch_idx   = bus_addr[ADDR_W-1:WIN_SHIFT];
   assign word_idx = bus_addr[WIN_SHIFT-1:2];
   assign lock_hit = (addr_ext == LOCK_OFS);

   xmb_keygate #(.KEY(KEY)) u_key (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_we && lock_hit),
      .wdata      (bus_wdata),
      .unlocked_o (unlocked)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_hit[c] = (ch_idx == CH_W'(c));
      xmb_channel #(.REQ_W(REQ_W), .DATA_WORDS(DATA_WORDS)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_we && ch_hit[c] && unlocked),
         .word_idx (word_idx),
         .wdata    (bus_wdata),
         .rdata    (ch_rd[c]),
         .owner_o  (owner_all[c]),
         .state_o  (state_all[c]),
         .irq_o    (irq_ch[c])
      );
   end

   xmb_irq_merge #(.NUM_CH(NUM_CH), .REQ_W(REQ_W)) u_irq (
      .irq_ch (irq_ch),
      .irq_o  (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (lock_hit) bus_rdata = {31'b0, ~unlocked};
      for (int c = 0; c < NUM_CH; c++)
         if (ch_hit[c]) bus_rdata = ch_rd[c];
   end
endmodule

// File: rtl/xmb_checker.sv
`timescale 1ns/1ps
module xmb_checker #(
   parameter int NUM_CH = 5,
   parameter int REQ_W  = 6
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         unlocked,
   input logic [NUM_CH-1:0][REQ_W-1:0] owner_all,
   input logic [NUM_CH-1:0][3:0]       state_all
);
   // R2: nothing in a channel moves while the key is closed
   a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(owner_all));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      a_r3_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(owner_all[c]));
      a_r6_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(state_all[c]));
      a_r5_free_iff_no_owner: assert property (@(posedge clk) disable iff (!rst_n)
         (state_all[c] == 4'b0001) == (owner_all[c] == '0));
      a_r7_sent_from_claim: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(state_all[c][2]) |-> $past(state_all[c][1] || state_all[c][3]));
      a_r8_ack_after_sent: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(state_all[c][3]) |-> $past(state_all[c][2]));
   end
endmodule

bind xcpu_mailbox xmb_checker #(.NUM_CH(NUM_CH), .REQ_W(REQ_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .unlocked  (unlocked),
   .owner_all (owner_all),
   .state_all (state_all)
);

// File: tb/sim_xcpu_mailbox.sv
`timescale 1ns/1ps
module sim_xcpu_mailbox;
   localparam logic [31:0] KEY  = 32'h1ACCE551;
   localparam logic [11:0] LOCK = 12'hA00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  irq;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   xcpu_mailbox u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [11:0] ad(input int ch, input int off);
      return 12'(ch * 64 + off);
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic t_reset;
      rd_chk("R2 lock at reset", LOCK, 32'h1);
      rd_chk("R6 free mode", ad(0, 'h10), 32'h10);
      rd_chk("R1 owner reset", ad(0, 'h00), 32'h0);
      chk("R10 irq reset", 32'(irq), 32'h0);
      rd_chk("R1 no channel window", ad(7, 'h10), 32'h0);
   endtask

   task automatic t_lock;
      wr(ad(0, 'h00), 32'h1);
      rd_chk("R2 write while locked", ad(0, 'h00), 32'h0);
      wr(LOCK, 32'h1234_5678);
      rd_chk("R2 wrong key", LOCK, 32'h1);
      wr(LOCK, KEY);
      rd_chk("R2 key opens", LOCK, 32'h0);
      wr(LOCK, 32'h0);
      rd_chk("R2 relock", LOCK, 32'h1);
      wr(ad(0, 'h00), 32'h1);
      rd_chk("R2 write after relock", ad(0, 'h00), 32'h0);
      wr(LOCK, KEY);
   endtask

   task automatic t_claim;
      wr(ad(2, 'h10), 32'h1);
      rd_chk("R6 mode write on free channel", ad(2, 'h10), 32'h10);
      wr(ad(1, 'h00), 32'h3);
      rd_chk("R3 two-bit id", ad(1, 'h00), 32'h0);
      wr(ad(1, 'h00), 32'h40);
      rd_chk("R3 id above width", ad(1, 'h00), 32'h0);
      wr(ad(1, 'h00), 32'h2);
      rd_chk("R3 claim readback", ad(1, 'h00), 32'h2);
      rd_chk("R6 claimed mode", ad(1, 'h10), 32'h20);
      wr(ad(1, 'h00), 32'h1);
      rd_chk("R4 foreign claim", ad(1, 'h00), 32'h2);
   endtask

   task automatic t_auto;
      wr(ad(1, 'h10), 32'h1);
      rd_chk("R6 auto bit", ad(1, 'h10), 32'h21);
      wr(ad(1, 'h14), 32'h35);
      wr(ad(1, 'h20), 32'h0001_0003);
      wr(ad(1, 'h24), 32'h0000_0102);
      rd_chk("R1 data word 0", ad(1, 'h20), 32'h0001_0003);
      rd_chk("R1 data word 1", ad(1, 'h24), 32'h0000_0102);
      wr(ad(1, 'h1C), 32'h1);
      rd_chk("R7 send by non-owner", ad(1, 'h10), 32'h21);
      wr(ad(1, 'h1C), 32'h2);
      rd_chk("R7 sent mode", ad(1, 'h10), 32'h41);
      rd_chk("R7 pending all others", ad(1, 'h18), 32'h3D);
      chk("R10 masked irq after send", 32'(irq), 32'h08);
      wr(ad(1, 'h18), 32'h8);
      rd_chk("R8 acked mode", ad(1, 'h10), 32'h81);
      rd_chk("R8 pending after ack", ad(1, 'h18), 32'h37);
      chk("R8 owner irq", 32'(irq), 32'h02);
      wr(ad(1, 'h18), 32'h2);
      chk("R11 owner irq cleared", 32'(irq), 32'h0);
      rd_chk("R11 pending after owner clear", ad(1, 'h18), 32'h35);
      wr(ad(1, 'h00), 32'h2);
      rd_chk("R5 owner freed", ad(1, 'h00), 32'h0);
      rd_chk("R5 mode free", ad(1, 'h10), 32'h10);
      rd_chk("R5 mask cleared", ad(1, 'h14), 32'h0);
      rd_chk("R5 pending cleared", ad(1, 'h18), 32'h0);
   endtask

   task automatic t_manual;
      wr(ad(3, 'h00), 32'h4);
      wr(ad(3, 'h04), 32'h1);
      wr(ad(3, 'h04), 32'h8);
      rd_chk("R1 target set", ad(3, 'h0C), 32'h9);
      wr(ad(3, 'h08), 32'h1);
      rd_chk("R1 target clear", ad(3, 'h0C), 32'h8);
      wr(ad(3, 'h1C), 32'h4);
      rd_chk("R7 target pending", ad(3, 'h18), 32'h8);
      chk("R10 target irq", 32'(irq), 32'h08);
      wr(ad(3, 'h18), 32'h8);
      rd_chk("R9 stays sent", ad(3, 'h10), 32'h40);
      chk("R9 irq dropped", 32'(irq), 32'h0);
      wr(ad(3, 'h00), 32'h4);
      rd_chk("R5 manual release", ad(3, 'h10), 32'h10);
   endtask

   task automatic t_mask;
      wr(ad(0, 'h00), 32'h1);
      wr(ad(0, 'h1C), 32'h1);
      wr(ad(0, 'h14), 32'h3E);
      chk("R10 fully masked", 32'(irq), 32'h0);
      rd_chk("R10 pending kept", ad(0, 'h18), 32'h3E);
      wr(ad(0, 'h14), 32'h0);
      chk("R10 unmasked", 32'(irq), 32'h3E);
      wr(ad(0, 'h00), 32'h1);
      chk("R5 irq after release", 32'(irq), 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lock();
      t_claim();
      t_auto();
      t_manual();
      t_mask();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule